// File: doc/BRIEF.md
# Prescaled 8-bit PWM generator

This block makes a single pulse-width-modulated output, intended for dimming a display backlight. Every period is 256 counts long. A count advances on a prescaled tick, which the block makes by dividing a selected source tick by a power of two between 1 and 64. Two tick-enable inputs stand in for the clock sources: a slow source and a fast (system-rate) source. Clock generation and clock gating are not modelled.

Software loads a 16-bit configuration word that holds the compare value, the polarity and the prescaler. It starts the generator with a one-cycle enable strobe and stops it with a one-cycle disable strobe. A status pin confirms each change after a fixed synchronisation delay. While the generator runs, a new configuration takes effect only at the next period boundary, so no period is ever cut short or glitched. All control and status pins are plain level or strobe signals. The block has no streaming data path, so it has no valid/ready handshake and no back-pressure.

Top module: `pwm_backlight_gen`

## Requirements
- R1: The compare value is held in bits 15:8 of the configuration word. With polarity 1, each period holds exactly compare × 2^p cycles of fast ticks at high level, where p is the effective prescaler.
- R2: The polarity is bit 4 of the configuration word. When it is 1, the output is high while the count is below the compare value. When it is 0, the output is the inverse, so it is low for compare × 2^p ticks of each period.
- R3: The prescaler is held in bits 2:0. One count lasts 2^p source ticks, and one period lasts 256 × 2^p source ticks.
- R4: A prescaler value of 7 behaves exactly like 6.
- R5: When the src_sel pin is 0, counting advances only on slow_tick. When it is 1, counting advances only on fast_tick. The source that is not selected has no effect on the output.
- R6: If the generator is idle, an accepted enable strobe sets status to 1 on the third rising edge after the edge that samples the strobe. An accepted disable strobe clears status to 0 with the same timing. On the two edges before that, status keeps its old value.
- R7: A strobe that arrives while a change is still pending is ignored. If enable and disable are asserted in the same cycle, disable wins.
- R8: While the generator runs, a configuration write takes effect at the start of the next 256-count period. While it is stopped, a write takes effect on the next cycle.
- R9: While stopped, the counter is held at 0 and the output sits at the inactive level, which is the inverse of the polarity. After reset the configuration is all zeros, so status is 0 and the output is 1.
- R10: A compare value of 0 never drives the output to its active level. A compare value of 255 gives a duty of 255/256, which is the largest duty available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration word: compare in bits 15:8, polarity in bit 4, prescaler in bits 2:0 |
| src_sel | input | 1 | Count source select: 0 selects slow_tick, 1 selects fast_tick |
| slow_tick | input | 1 | Slow source tick enable |
| fast_tick | input | 1 | Fast source tick enable |
| en_strobe | input | 1 | Write-one start strobe |
| dis_strobe | input | 1 | Write-one stop strobe |
| status | output | 1 | 1 while the generator is running |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions assume that the inputs are sampled only on rising clock edges. They also assume that a prescaler of 7 never reaches the active configuration, and that the shadow configuration changes during a run only at a counter wrap. The bench changes every input on the falling edge and holds each strobe for exactly one cycle. It keeps fast_tick steady at 1 during duty measurements, so each measurement window is exactly one period of fast ticks. In the frozen-counter test, the bench pulses slow_tick by hand, which lets it place a configuration write in the middle of a period and observe the result.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int CNT_W   = 8;
  localparam int PS_W    = 3;
  localparam int PS_MAX  = 6;
  localparam int CFG_W   = 16;
  localparam int CMP_LSB = 8;
  localparam int POL_BIT = 4;

  typedef struct packed {
    logic [CNT_W-1:0] cmp;
    logic             pol;
    logic [PS_W-1:0]  ps;
  } pwm_cfg_t;

  function automatic pwm_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
    pwm_cfg_t c;
    c.cmp = w[CMP_LSB +: CNT_W];
    c.pol = w[POL_BIT];
    c.ps  = (w[PS_W-1:0] > PS_W'(PS_MAX)) ? PS_W'(PS_MAX) : w[PS_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/pwm_cfg_buf.sv
module pwm_cfg_buf
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             running,
  input  logic             wrap,
  output pwm_cfg_t         active
);
  pwm_cfg_t pend_q, pend_nx;

  always_comb begin
    pend_nx = pend_q;
    if (cfg_we) pend_nx = unpack_cfg(cfg_wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      active <= '0;
    end else begin
      pend_q <= pend_nx;
      if (!running || wrap) active <= pend_nx;
    end
  end

  p_ps_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active.ps <= PS_W'(PS_MAX));

  p_shadow_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && !$stable(active)) |-> $past(wrap));
endmodule

// File: rtl/pwm_tick_div.sv
module pwm_tick_div
  import pwm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            running,
  input  logic            src_tick,
  input  logic [PS_W-1:0] ps,
  output logic            ptick
);
  localparam int DIV_W = PS_MAX;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   full_mask;
  logic [DIV_W-1:0] mask;

  assign full_mask = (DIV_W+1)'(1) << ps;
  assign mask      = DIV_W'(full_mask - 1'b1);
  assign ptick     = running && src_tick && (div_q == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || !running) div_q <= '0;
    else if (src_tick)      div_q <= ptick ? '0 : div_q + 1'b1;
  end

  p_div_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= mask || $past(div_q) <= mask);
endmodule

// File: rtl/pwm_run_ctl.sv
module pwm_run_ctl #(
  parameter int SYNC_DLY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_strobe,
  input  logic dis_strobe,
  output logic running
);
  localparam int DW = $clog2(SYNC_DLY + 1);
  logic          pend_q;
  logic          tgt_q;
  logic [DW-1:0] dly_q;
  logic          accept;

  assign accept = (en_strobe || dis_strobe) && !pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      tgt_q   <= 1'b0;
      dly_q   <= '0;
      running <= 1'b0;
    end else if (accept) begin
      pend_q <= 1'b1;
      tgt_q  <= !dis_strobe;
      dly_q  <= DW'(SYNC_DLY - 1);
    end else if (pend_q) begin
      if (dly_q == '0) begin
        running <= tgt_q;
        pend_q  <= 1'b0;
      end else begin
        dly_q <= dly_q - 1'b1;
      end
    end
  end

  p_hold_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> $stable(running));

  p_ignore_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && (en_strobe || dis_strobe)) |=> $stable(tgt_q));
endmodule

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  logic             ptick,
  input  logic [CNT_W-1:0] cmp,
  output logic             wrap,
  output logic             active_phase
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap         = ptick && (cnt_q == '1);
  assign active_phase = running && (cnt_q < cmp);

  always_ff @(posedge clk) begin
    if (!rst_n || !running) cnt_q <= '0;
    else if (ptick)         cnt_q <= cnt_q + 1'b1;
  end

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!running) |-> cnt_q == '0);

  p_zero_cmp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp == '0) |-> !active_phase);
endmodule

// File: rtl/pwm_backlight_gen.sv
module pwm_backlight_gen
  import pwm_pkg::*;
#(
  parameter int SYNC_DLY = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             src_sel,
  input  logic             slow_tick,
  input  logic             fast_tick,
  input  logic             en_strobe,
  input  logic             dis_strobe,
  output logic             status,
  output logic             pwm_out
);
  logic     running, ptick, wrap, phase, src_tick;
  pwm_cfg_t act;

  assign src_tick = src_sel ? fast_tick : slow_tick;

  pwm_run_ctl #(.SYNC_DLY(SYNC_DLY)) u_ctl (
    .clk(clk), .rst_n(rst_n), .en_strobe(en_strobe),
    .dis_strobe(dis_strobe), .running(running));

  pwm_cfg_buf u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .running(running), .wrap(wrap), .active(act));

  pwm_tick_div u_div (
    .clk(clk), .rst_n(rst_n), .running(running), .src_tick(src_tick),
    .ps(act.ps), .ptick(ptick));

  pwm_period_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .running(running), .ptick(ptick),
    .cmp(act.cmp), .wrap(wrap), .active_phase(phase));

  assign status  = running;
  assign pwm_out = act.pol ? phase : !phase;

  p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !status |-> (pwm_out == !act.pol));
endmodule

// File: tb/tb_pwm_backlight_gen.sv
module tb_pwm_backlight_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, src_sel = 1, slow_tick = 0, fast_tick = 1;
  logic en_strobe = 0, dis_strobe = 0;
  logic [15:0] cfg_wdata = '0;
  logic status, pwm_out;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_backlight_gen dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int cmp, input int pol, input int ps);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = 16'((cmp << 8) | (pol << 4) | ps);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic strobe(input bit en, input bit dis);
    @(negedge clk);
    en_strobe = en; dis_strobe = dis;
    @(negedge clk);
    en_strobe = 0; dis_strobe = 0;
  endtask

  task automatic start_chk(input bit exp_new);
    strobe(1, 0);
    @(negedge clk); @(negedge clk);
    chk("R6 status before delay", status, !exp_new);
    @(negedge clk);
    chk("R6 status after enable", status, 1);
  endtask

  task automatic stop_chk();
    strobe(0, 1);
    @(negedge clk); @(negedge clk);
    chk("R6 status before delay", status, 1);
    @(negedge clk);
    chk("R6 status after disable", status, 0);
  endtask

  task automatic measure(input int p, output int hi);
    hi = 0;
    for (int i = 0; i < p; i++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_slow(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_tick = 1;
      @(negedge clk); slow_tick = 0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int hi, pe, per;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset status", status, 0);
    chk("R9 reset output", pwm_out, 1);

    // R1 R2 R10: compare sweep at prescaler 0, both polarities
    for (int pol = 0; pol < 2; pol++) begin
      for (int c = 0; c <= 255; c += 17) begin
        wr(c, pol, 0);
        start_chk(1);
        measure(256, hi);
        chk(pol ? "R1 high count" : "R2 inverted high count", hi,
            pol ? c : 256 - c);
        stop_chk();
        chk("R9 idle level", pwm_out, !pol);
      end
    end
    wr(0, 1, 0); start_chk(1); measure(256, hi);
    chk("R10 cmp 0 never active", hi, 0); stop_chk();
    wr(255, 1, 0); start_chk(1); measure(256, hi);
    chk("R10 cmp 255 duty", hi, 255); stop_chk();

    // R3 R4: prescaler sweep including clamped 7
    for (int ps = 0; ps < 8; ps++) begin
      pe = (ps > 6) ? 6 : ps;
      per = 256 << pe;
      wr(64, 1, ps);
      start_chk(1);
      measure(per, hi);
      chk(ps == 7 ? "R4 clamp high count" : "R3 prescaled high count",
          hi, 64 << pe);
      stop_chk();
    end

    // R8 R9: write while stopped takes effect next cycle
    wr(10, 1, 0);
    chk("R8 stopped write pol1 idle", pwm_out, 0);
    wr(10, 0, 0);
    chk("R8 stopped write pol0 idle", pwm_out, 1);

    // R5 R8: slow source, frozen counter, mid-period write
    src_sel = 0; fast_tick = 1;
    wr(100, 1, 0);
    start_chk(1);
    chk("R5 count 0 active", pwm_out, 1);
    repeat (20) @(negedge clk);
    chk("R5 fast tick ignored", pwm_out, 1);
    pulse_slow(150);
    chk("R5 slow count 150", pwm_out, 0);
    wr(200, 1, 0);
    repeat (3) @(negedge clk);
    chk("R8 running write deferred", pwm_out, 0);
    pulse_slow(105);
    chk("R8 old cmp at 255", pwm_out, 0);
    pulse_slow(1);
    chk("R8 new cmp at wrap", pwm_out, 1);
    pulse_slow(150);
    chk("R8 new cmp at 150", pwm_out, 1);
    stop_chk();
    src_sel = 1;

    // R7: strobe during pending ignored; simultaneous strobes
    strobe(1, 0);
    strobe(0, 1);
    repeat (8) @(negedge clk);
    chk("R7 disable during pending ignored", status, 1);
    stop_chk();
    strobe(1, 1);
    repeat (8) @(negedge clk);
    chk("R7 disable wins", status, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule